// File: doc/BRIEF.md
# Timer Slave-Mode Trigger Controller

This block is an up-counter with a slave controller that lets a selected trigger input start it, zero it, or gate it. One of four raw inputs drives the trigger: an external trigger pin, two channel inputs that each have a polarity bit, and an internal trigger line from a companion timer. Every raw input passes through a synchronizer, and an edge detector follows it, so the controller reacts a fixed number of cycles after the input changes.

The counter can advance on every clock cycle. It can also advance only on synchronized active edges of the external trigger pin, while a different input serves as the trigger. The counter wraps to zero after it reaches the active reload value. A wrap, or a clear request when update reporting is allowed, raises an update pulse. The same event copies the preloaded reload value into the active reload register. A sticky trigger flag records slave events, and software clears it. The flag drives an interrupt line through an enable bit. Configuration arrives as plain inputs, and the enable bit, the flag clear and the reload preload are written through strobes.

Top module: `tmr_slave_ctl`

## Requirements
- R1: While reset is held, the counter reads 0, the enable bit, the trigger flag, the update pulse and the interrupt are all 0, and the active reload reads the reset reload parameter.
- R2: While the enable bit is 1 and slave mode is 000, the counter advances by one per cycle. In the cycle after it reaches the active reload it reads 0, and the update pulse is 1 for one cycle. A value written to the reload preload reaches the active reload only on an update event.
- R3: In start mode (mode 110), an active trigger edge sets the enable bit and the trigger flag. The input change is applied before clock edge k. The enable bit and the flag read 1 after edge k+2 and read 0 after edge k+1. The counter advances from edge k+3. Later trigger edges do not clear the enable bit.
- R4: In clear mode (mode 100), an active trigger edge sets the counter to 0 at edge k+2, and counting continues from 0. If the update-suppress bit is 0, the update pulse is 1 after that edge and the preload moves to the active reload. If the bit is 1, no update pulse occurs.
- R5: In gated mode (mode 101), the counter advances on an edge only while the selected input was at its active level and the enable bit is 1. With the enable bit at 0 the counter holds, whatever the input level.
- R6: In gated mode, the trigger flag is set when counting starts and again when it stops. Each change is seen after edge k+2.
- R7: A polarity bit of 0 makes a rising edge or high level active. A polarity bit of 1 makes a falling edge or low level active.
- R8: Trigger select 101 takes channel 1 with its polarity, 110 takes channel 2 with its polarity, and 111 takes the external pin with its polarity. Select 100 takes channel 1 on both edges with no polarity. Selects 000 to 011 take the internal trigger, rising edge only.
- R9: With the external clock bit set, the counter advances once per synchronized active edge of the external pin and never otherwise.
- R10: With the external clock bit set, selecting the external pin as trigger (111) produces no trigger events.
- R11: A one-cycle flag-clear strobe sets the trigger flag to 0. If a new trigger sets the flag in the same cycle, the flag ends at 1.
- R12: The interrupt output is 1 exactly when the trigger flag and the interrupt enable are both 1.
- R13: Slave mode 000 ignores trigger events: the trigger flag stays 0, and only the enable bit controls the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 3 | Slave mode: 000 off, 100 clear, 101 gated, 110 start |
| cfg_tsel | input | 3 | Trigger source select |
| cfg_pol_ch1 | input | 1 | Channel 1 polarity |
| cfg_pol_ch2 | input | 1 | Channel 2 polarity |
| cfg_pol_etr | input | 1 | External pin polarity |
| cfg_ext_clk | input | 1 | Count on external pin edges |
| cfg_urs | input | 1 | Suppress update on trigger clear |
| cfg_tie | input | 1 | Trigger interrupt enable |
| cen_wr | input | 1 | Enable bit write strobe |
| cen_wdata | input | 1 | Enable bit write value |
| tif_clr | input | 1 | Trigger flag clear strobe |
| arr_wr | input | 1 | Reload preload write strobe |
| arr_wdata | input | CNT_W | Reload preload value |
| etr_in | input | 1 | Raw external trigger pin |
| ch1_in | input | 1 | Raw channel 1 input |
| ch2_in | input | 1 | Raw channel 2 input |
| itr_in | input | 1 | Internal trigger from companion timer |
| cnt_o | output | CNT_W | Counter value |
| cen_o | output | 1 | Counter enable bit |
| tif_o | output | 1 | Trigger flag |
| uev_o | output | 1 | Update event pulse |
| irq_o | output | 1 | Trigger interrupt request |
| arr_o | output | CNT_W | Active reload value |

## Verification
The bench uses CNT_W = 16, a reset reload of 0x36 and a two-stage synchronizer. The small reset reload lets the bench reach a natural wrap, and a preload that has no effect until then, within about sixty cycles. With two synchronizer stages the trigger latency is a fixed constant, so each start, clear, gate change and external clock tick is checked on the exact cycle it should take effect. A table loop covers every trigger-select code against the inputs it should and should not react to.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   // slave mode codes
   localparam logic [2:0] SM_OFF   = 3'b000;
   localparam logic [2:0] SM_CLEAR = 3'b100;
   localparam logic [2:0] SM_GATED = 3'b101;
   localparam logic [2:0] SM_START = 3'b110;
   // trigger select codes (000..011 fall to the internal trigger)
   localparam logic [2:0] TS_CH1_ANY = 3'b100;
   localparam logic [2:0] TS_CH1     = 3'b101;
   localparam logic [2:0] TS_CH2     = 3'b110;
   localparam logic [2:0] TS_EXT     = 3'b111;
   // bit positions of the raw input vector
   localparam int IX_EXT = 0;
   localparam int IX_CH1 = 1;
   localparam int IX_CH2 = 2;
   localparam int IX_ITR = 3;
   localparam int N_SRC  = 4;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] lvl,
   output logic [N-1:0] lvl_d
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-1:0], din[i]};
      end
      assign lvl[i]   = sh[STAGES-1];
      assign lvl_d[i] = sh[STAGES];
   end
endmodule

// File: rtl/tsc_trig_sel.sv
module tsc_trig_sel
   import tsc_pkg::*;
(
   input  logic [N_SRC-1:0] lvl,
   input  logic [N_SRC-1:0] lvl_d,
   input  logic [2:0]       tsel,
   input  logic             pol_ch1,
   input  logic             pol_ch2,
   input  logic             pol_etr,
   input  logic             ext_clk,
   output logic             trg_lvl,
   output logic             trg_edge,
   output logic             tick
);
   logic c1_a, c1_ad, c2_a, c2_ad, e_a, e_ad;

   assign c1_a  = lvl[IX_CH1]   ^ pol_ch1;
   assign c1_ad = lvl_d[IX_CH1] ^ pol_ch1;
   assign c2_a  = lvl[IX_CH2]   ^ pol_ch2;
   assign c2_ad = lvl_d[IX_CH2] ^ pol_ch2;
   assign e_a   = lvl[IX_EXT]   ^ pol_etr;
   assign e_ad  = lvl_d[IX_EXT] ^ pol_etr;

   always_comb begin
      unique case (tsel)
         TS_CH1_ANY: begin
            trg_lvl  = lvl[IX_CH1];
            trg_edge = lvl[IX_CH1] ^ lvl_d[IX_CH1];
         end
         TS_CH1: begin
            trg_lvl  = c1_a;
            trg_edge = c1_a & ~c1_ad;
         end
         TS_CH2: begin
            trg_lvl  = c2_a;
            trg_edge = c2_a & ~c2_ad;
         end
         TS_EXT: begin
            // pin already used as counting clock: not a legal trigger
            trg_lvl  = e_a & ~ext_clk;
            trg_edge = e_a & ~e_ad & ~ext_clk;
         end
         default: begin
            trg_lvl  = lvl[IX_ITR];
            trg_edge = lvl[IX_ITR] & ~lvl_d[IX_ITR];
         end
      endcase
   end

   assign tick = ext_clk ? (e_a & ~e_ad) : 1'b1;
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
   parameter int          CNT_W   = 16,
   parameter logic [CNT_W-1:0] ARR_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic             urs,
   input  logic             arr_wr,
   input  logic [CNT_W-1:0] arr_wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] arr_act,
   output logic             uev
);
   logic [CNT_W-1:0] arr_pre;
   logic             wrap, uev_d;

   assign wrap  = adv & (cnt == arr_act);
   assign uev_d = clr ? ~urs : wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         arr_pre <= ARR_RST;
         arr_act <= ARR_RST;
         uev     <= 1'b0;
      end else begin
         if (clr)       cnt <= '0;
         else if (wrap) cnt <= '0;
         else if (adv)  cnt <= cnt + 1'b1;
         if (arr_wr) arr_pre <= arr_wdata;
         if (uev_d)  arr_act <= arr_pre;
         uev <= uev_d;
      end
   end
endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl
   import tsc_pkg::*;
#(
   parameter int          CNT_W       = 16,
   parameter int          SYNC_STAGES = 2,
   parameter logic [CNT_W-1:0] ARR_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cfg_mode,
   input  logic [2:0]       cfg_tsel,
   input  logic             cfg_pol_ch1,
   input  logic             cfg_pol_ch2,
   input  logic             cfg_pol_etr,
   input  logic             cfg_ext_clk,
   input  logic             cfg_urs,
   input  logic             cfg_tie,
   input  logic             cen_wr,
   input  logic             cen_wdata,
   input  logic             tif_clr,
   input  logic             arr_wr,
   input  logic [CNT_W-1:0] arr_wdata,
   input  logic             etr_in,
   input  logic             ch1_in,
   input  logic             ch2_in,
   input  logic             itr_in,
   output logic [CNT_W-1:0] cnt_o,
   output logic             cen_o,
   output logic             tif_o,
   output logic             uev_o,
   output logic             irq_o,
   output logic [CNT_W-1:0] arr_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("tmr_slave_ctl: CNT_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_slave_ctl: SYNC_STAGES must be at least 2");
   end

   logic [N_SRC-1:0] raw, lvl, lvl_d;
   logic trg_lvl, trg_edge, tick;
   logic is_start, is_clear, is_gated;
   logic cen_q, tif_q, gate_prev, gate_now, run, cnt_adv, trg_clr, tif_set;

   always_comb begin
      raw         = '0;
      raw[IX_EXT] = etr_in;
      raw[IX_CH1] = ch1_in;
      raw[IX_CH2] = ch2_in;
      raw[IX_ITR] = itr_in;
   end

   tsc_sync #(.N(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw), .lvl(lvl), .lvl_d(lvl_d)
   );

   tsc_trig_sel u_sel (
      .lvl(lvl), .lvl_d(lvl_d), .tsel(cfg_tsel),
      .pol_ch1(cfg_pol_ch1), .pol_ch2(cfg_pol_ch2), .pol_etr(cfg_pol_etr),
      .ext_clk(cfg_ext_clk),
      .trg_lvl(trg_lvl), .trg_edge(trg_edge), .tick(tick)
   );

   assign is_start = (cfg_mode == SM_START);
   assign is_clear = (cfg_mode == SM_CLEAR);
   assign is_gated = (cfg_mode == SM_GATED);

   assign gate_now = cen_q & trg_lvl;
   assign run      = is_gated ? gate_now : cen_q;
   assign cnt_adv  = run & tick;
   assign trg_clr  = is_clear & trg_edge;
   assign tif_set  = ((is_start | is_clear) & trg_edge)
                   | (is_gated & (gate_now ^ gate_prev));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cen_q     <= 1'b0;
         tif_q     <= 1'b0;
         gate_prev <= 1'b0;
      end else begin
         if (is_start && trg_edge) cen_q <= 1'b1;
         else if (cen_wr)          cen_q <= cen_wdata;
         if (tif_set)      tif_q <= 1'b1;
         else if (tif_clr) tif_q <= 1'b0;
         gate_prev <= gate_now;
      end
   end

   tsc_counter #(.CNT_W(CNT_W), .ARR_RST(ARR_RST)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(trg_clr), .adv(cnt_adv), .urs(cfg_urs),
      .arr_wr(arr_wr), .arr_wdata(arr_wdata),
      .cnt(cnt_o), .arr_act(arr_o), .uev(uev_o)
   );

   assign cen_o = cen_q;
   assign tif_o = tif_q;
   assign irq_o = tif_q & cfg_tie;
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       mode,
   input logic             urs,
   input logic             cen_wr,
   input logic             cen,
   input logic             tif,
   input logic             tif_set,
   input logic             clr,
   input logic             adv,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] arr_act,
   input logic             uev
);
   AST_WRAP_UEV: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr) && $past(adv) && $past(cnt) == $past(arr_act)) |-> (cnt == '0 && uev)); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr) && !$past(adv)) |-> $stable(cnt)); // R5
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> cnt == '0); // R4
   AST_URS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr) && $past(urs)) |-> !uev); // R4
   AST_START_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b110 && $past(mode) == 3'b110 && $past(cen) && !$past(cen_wr)) |-> cen); // R3
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tif_set) |-> tif); // R11
   AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 3'b000 && !$past(tif)) |-> !tif); // R13
endmodule

bind tmr_slave_ctl tsc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .urs(cfg_urs), .cen_wr(cen_wr),
   .cen(cen_q), .tif(tif_q), .tif_set(tif_set), .clr(trg_clr), .adv(cnt_adv),
   .cnt(cnt_o), .arr_act(arr_o), .uev(uev_o)
);

// File: tb/tmr_slave_ctl_tb.sv
`timescale 1ns/1ps
module tmr_slave_ctl_tb;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] cfg_mode = 3'b000, cfg_tsel = 3'b000;
   logic cfg_pol_ch1 = 0, cfg_pol_ch2 = 0, cfg_pol_etr = 0, cfg_ext_clk = 0;
   logic cfg_urs = 0, cfg_tie = 0, cen_wr = 0, cen_wdata = 0, tif_clr = 0, arr_wr = 0;
   logic [W-1:0] arr_wdata = '0;
   logic etr_in = 0, ch1_in = 0, ch2_in = 0, itr_in = 0;
   logic [W-1:0] cnt_o, arr_o;
   logic cen_o, tif_o, uev_o, irq_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;
   logic [31:0] c;

   always #2.5 clk = ~clk;

   tmr_slave_ctl #(.CNT_W(W), .SYNC_STAGES(2), .ARR_RST(16'h0036)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_tsel(cfg_tsel),
      .cfg_pol_ch1(cfg_pol_ch1), .cfg_pol_ch2(cfg_pol_ch2), .cfg_pol_etr(cfg_pol_etr),
      .cfg_ext_clk(cfg_ext_clk), .cfg_urs(cfg_urs), .cfg_tie(cfg_tie),
      .cen_wr(cen_wr), .cen_wdata(cen_wdata), .tif_clr(tif_clr),
      .arr_wr(arr_wr), .arr_wdata(arr_wdata),
      .etr_in(etr_in), .ch1_in(ch1_in), .ch2_in(ch2_in), .itr_in(itr_in),
      .cnt_o(cnt_o), .cen_o(cen_o), .tif_o(tif_o), .uev_o(uev_o),
      .irq_o(irq_o), .arr_o(arr_o)
   );

   // {tsel[2:0], src[1:0] (0 ext,1 ch1,2 ch2,3 itr), start, end, pol, expect}
   localparam logic [8:0] VECS [11] = '{
      9'b000_11_0_1_0_1, 9'b011_11_0_1_0_1, 9'b000_01_0_1_0_0,
      9'b100_01_1_0_0_1, 9'b101_01_0_1_0_1, 9'b101_01_1_0_0_0,
      9'b101_01_1_0_1_1, 9'b110_10_0_1_0_1, 9'b110_01_0_1_0_0,
      9'b111_00_0_1_0_1, 9'b111_00_1_0_1_1
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic write_cen(input logic v);
      cen_wr = 1'b1; cen_wdata = v;
      step(1);
      cen_wr = 1'b0;
   endtask

   task automatic clear_flag();
      tif_clr = 1'b1;
      step(1);
      tif_clr = 1'b0;
   endtask

   task automatic etr_pulse();
      etr_in = 1'b1; step(2);
      etr_in = 1'b0; step(2);
   endtask

   task automatic set_src(input logic [1:0] src, input logic v);
      case (src)
         2'd0: etr_in = v;
         2'd1: ch1_in = v;
         2'd2: ch2_in = v;
         default: itr_in = v;
      endcase
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=complete");
         finish_run();
      end
   end

   initial begin
      step(3);
      // R1 reset state
      check("R1 cnt", cnt_o, 0);
      check("R1 cen", cen_o, 0);
      check("R1 tif", tif_o, 0);
      check("R1 uev", uev_o, 0);
      check("R1 irq", irq_o, 0);
      check("R1 arr", arr_o, 32'h36);
      rst_n = 1'b1;
      step(2);

      // R13: mode off ignores internal trigger
      itr_in = 1'b1; step(5);
      check("R13 tif", tif_o, 0);
      itr_in = 1'b0; step(4);

      // R2: free run, wrap, preload timing
      arr_wr = 1'b1; arr_wdata = 16'h0003; step(1); arr_wr = 1'b0;
      check("R2 preload held", arr_o, 32'h36);
      write_cen(1'b1);
      check("R2 start", cnt_o, 0);
      step(32'h36);
      check("R2 top", cnt_o, 32'h36);
      check("R2 no uev", uev_o, 0);
      step(1);
      check("R2 wrap", cnt_o, 0);
      check("R2 uev", uev_o, 1);
      check("R2 arr load", arr_o, 3);
      step(3);
      check("R2 short", cnt_o, 3);
      step(1);
      check("R2 wrap2", cnt_o, 0);
      check("R2 uev2", uev_o, 1);
      write_cen(1'b0);

      // R4: clear-mode trigger with updates allowed loads the preload
      cfg_mode = 3'b100; cfg_tsel = 3'b000;
      arr_wr = 1'b1; arr_wdata = 16'h00FF; step(1); arr_wr = 1'b0;
      itr_in = 1'b1; step(3);
      check("R4 clr", cnt_o, 0);
      check("R4 uev", uev_o, 1);
      check("R4 arr", arr_o, 32'hFF);
      itr_in = 1'b0;
      write_cen(1'b1);
      step(10);
      cfg_tsel = 3'b101; step(2); clear_flag();
      c = cnt_o; ch1_in = 1'b1;
      step(2);
      check("R4 before", cnt_o, c + 2);
      step(1);
      check("R4 cleared", cnt_o, 0);
      check("R4 uev urs0", uev_o, 1);
      check("R4 tif", tif_o, 1);
      step(1);
      check("R4 continue", cnt_o, 1);
      check("R4 uev off", uev_o, 0);
      cfg_urs = 1'b1; ch1_in = 1'b0; step(6);
      ch1_in = 1'b1; step(3);
      check("R4 cleared urs1", cnt_o, 0);
      check("R4 no uev urs1", uev_o, 0);
      ch1_in = 1'b0; cfg_urs = 1'b0;
      write_cen(1'b0);

      // R3: start mode latency and stickiness
      cfg_mode = 3'b110; cfg_tsel = 3'b110; step(3); clear_flag();
      c = cnt_o; ch2_in = 1'b1;
      step(2);
      check("R3 not yet tif", tif_o, 0);
      check("R3 not yet cen", cen_o, 0);
      step(1);
      check("R3 tif", tif_o, 1);
      check("R3 cen", cen_o, 1);
      check("R3 cnt hold", cnt_o, c);
      step(1);
      check("R3 cnt run", cnt_o, c + 1);
      ch2_in = 1'b0; step(3); ch2_in = 1'b1; step(4);
      check("R3 sticky", cen_o, 1);
      ch2_in = 1'b0;
      write_cen(1'b0);
      cfg_mode = 3'b000;

      // R12 interrupt gating
      cfg_tie = 1'b1; step(1);
      check("R12 irq on", irq_o, 1);
      cfg_tie = 1'b0; step(1);
      check("R12 irq off", irq_o, 0);
      cfg_tie = 1'b1;

      // R11 clear and collision
      clear_flag();
      check("R11 cleared", tif_o, 0);
      check("R12 irq follows", irq_o, 0);
      cfg_mode = 3'b100; cfg_tsel = 3'b000;
      itr_in = 1'b1; step(2);
      tif_clr = 1'b1; step(1); tif_clr = 1'b0;
      check("R11 set wins", tif_o, 1);
      itr_in = 1'b0; step(3); clear_flag();

      // R5 R6 R7 gated mode, active low
      cfg_mode = 3'b101; cfg_tsel = 3'b101; cfg_pol_ch1 = 1'b1; ch1_in = 1'b1;
      write_cen(1'b1);
      step(4); clear_flag();
      c = cnt_o; step(5);
      check("R5 inactive hold", cnt_o, c);
      c = cnt_o; ch1_in = 1'b0; step(3);
      check("R7 low level counts", cnt_o, c + 1);
      check("R6 start flag", tif_o, 1);
      step(2); clear_flag();
      c = cnt_o; ch1_in = 1'b1; step(3);
      check("R5 stop", cnt_o, c + 2);
      check("R6 stop flag", tif_o, 1);
      write_cen(1'b0);
      ch1_in = 1'b0; step(5);
      c = cnt_o; step(5);
      check("R5 cen0 hold", cnt_o, c);
      ch1_in = 1'b1; cfg_pol_ch1 = 1'b0;

      // R9 external clock with ch1 start trigger
      cfg_mode = 3'b110; cfg_tsel = 3'b101; ch1_in = 1'b0; cfg_ext_clk = 1'b1;
      step(4); clear_flag();
      c = cnt_o; etr_pulse(); etr_pulse();
      check("R9 no count before start", cnt_o, c);
      ch1_in = 1'b1; step(4);
      check("R9 started", cen_o, 1);
      c = cnt_o; step(6);
      check("R9 idle hold", cnt_o, c);
      etr_pulse(); etr_pulse(); etr_pulse();
      check("R9 ext count", cnt_o, c + 3);

      // R10 ext pin as trigger while used as clock
      cfg_mode = 3'b100; cfg_tsel = 3'b111; step(2); clear_flag();
      c = cnt_o; etr_pulse(); step(2);
      check("R10 no flag", tif_o, 0);
      check("R10 no clear", cnt_o, c + 1);
      cfg_ext_clk = 1'b0; ch1_in = 1'b0;
      write_cen(1'b0);

      // R8 R7 trigger select table
      cfg_mode = 3'b100;
      for (int i = 0; i < 11; i++) begin : vloop
         logic [8:0] v;
         v = VECS[i];
         etr_in = 0; ch1_in = 0; ch2_in = 0; itr_in = 0;
         cfg_tsel = v[8:6];
         cfg_pol_ch1 = v[1]; cfg_pol_ch2 = v[1]; cfg_pol_etr = v[1];
         set_src(v[5:4], v[3]);
         step(5); clear_flag();
         set_src(v[5:4], v[2]);
         step(5);
         check($sformatf("R8 R7 vector %0d tif", i), tif_o, v[0]);
      end

      done = 1;
      finish_run();
   end
endmodule